// File: doc/BRIEF.md
# Pixel Zero-Suppression Hit Extractor

This block takes raw samples from a pixel matrix that is read out as four quadrants in parallel. Every cycle it may receive one pixel address together with one sample and one pedestal per quadrant. Each quadrant has its own lane. The lane keeps the previous frame's sample for every address in a frame memory. It forms the correlated-double-sampling difference, removes the pedestal, and compares the result with a signed threshold. The lane then stores the surviving hits in a small local FIFO.

An output packer merges the four lane FIFOs into one 32-bit word stream with a valid/ready handshake. The ready input stands for the free space of the downstream output FIFO. Each frame becomes one event packet: a header word, the hit words, and a trailer word. The trailer is written only after all four lanes have closed the frame. The scan side never stalls. If a lane FIFO runs out of room, that lane's hits are lost and the loss is flagged in the trailer.

A raw mode keeps every pixel regardless of threshold, for offline pedestal and noise work. A frame is closed by a one-cycle `frame_done` pulse on a cycle that carries no pixel. Each frame must last long enough for the previous packet to drain.

Top module: `pixel_zs_extractor`

## Requirements
- R1: After reset, `out_valid` is 0. The first packet's header carries frame number 0, and each later packet's number is one higher.
- R2: The amplitude is the current sample, minus the sample stored at the same address in the previous frame, minus the signed pedestal, as a 14-bit signed value. Until the first `frame_done` after reset, the previous sample is taken as zero. Every pixel overwrites its stored sample.
- R3: In suppressed mode (`raw_mode`=0), a pixel yields a hit only when its amplitude is strictly greater than the signed `threshold`. An amplitude equal to the threshold yields nothing.
- R4: In raw mode (`raw_mode`=1), every pixel yields a hit word, whatever the threshold.
- R5: A hit word is {quadrant[31:30], row[29:22], column[21:14], amplitude[13:0]}, with row and column zero-extended. Quadrant q takes its sample and pedestal from bits [q*12 +: 12].
- R6: Each `frame_done` produces exactly one packet, even when the frame has no hits. The header has `out_sop`=1, bits [31:28]=4'hA and the frame number in [15:0]. The trailer has `out_eop`=1, bits [31:28]=4'hE, the overflow flag in bit 27 and the number of hit words in [15:0].
- R7: The hits of one quadrant leave in the order their pixels arrived. After the header, the quadrants are visited in fixed rotation.
- R8: A lane FIFO keeps at most FIFO_DEPTH-1 hits (7 by default) while its output is stalled. Further hits from that lane are dropped, and bit 27 of that frame's trailer is set. The next frame's trailer starts clear.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output word and its flags hold still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_mode | input | 1 | 1 keeps every pixel |
| threshold | input | 14 | Signed hit threshold |
| pix_valid | input | 1 | Pixel address and samples valid |
| frame_done | input | 1 | One-cycle end-of-frame pulse |
| pix_row | input | ROW_W | Pixel row inside the quadrant |
| pix_col | input | COL_W | Pixel column inside the quadrant |
| pix_samples | input | 4*SAMP_W | Raw samples, one per quadrant |
| pix_peds | input | 4*PED_W | Signed pedestals, one per quadrant |
| out_ready | input | 1 | Downstream can take a word |
| out_valid | output | 1 | Output word valid |
| out_sop | output | 1 | Output word is a header |
| out_eop | output | 1 | Output word is a trailer |
| out_data | output | 32 | Header, hit or trailer word |

## Verification
A frame memory that is written late or read at the wrong address shows up as wrong amplitudes in the next frame's hit words, so it is visible within one frame. A stuck overflow flag or hit counter shows up at the very next trailer. A lane that never posts its end-of-frame marker stops packets altogether, and the missing trailer shows up as a hang. A rotation pointer that skips a quadrant reorders or loses that quadrant's hits within the same packet.

// File: rtl/pzs_pkg.sv
package pzs_pkg;
  localparam int QUADS   = 4;
  localparam int AMP_W   = 14;
  localparam int FIELD_W = 8;
  // lane FIFO entry: {marker, row, col, amplitude}; a marker keeps its overflow flag in bit 0
  localparam int ENTRY_W = 1 + 2 * FIELD_W + AMP_W;
  localparam logic [3:0] HDR_TAG = 4'hA;
  localparam logic [3:0] TRL_TAG = 4'hE;

  typedef enum logic [0:0] {ARB_IDLE, ARB_DRAIN} arb_state_t;
endpackage

// File: rtl/pzs_hit_fifo.sv
module pzs_hit_fifo #(
  parameter int WIDTH = 31,
  parameter int DEPTH = 8     // power of two
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic                     rd_en,
  output logic [WIDTH-1:0]         rd_data,
  output logic                     empty,
  output logic [$clog2(DEPTH):0]   count
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= rd_ptr + 1'b1;
      count <= count + CNT_W'(wr_en) - CNT_W'(rd_en);
    end
  end

  assign rd_data = store[rd_ptr];
  assign empty   = (count == '0);
endmodule

// File: rtl/pzs_lane.sv
module pzs_lane
  import pzs_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int SAMP_W = 12,
  parameter int PED_W = 12,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     raw_mode,
  input  logic signed [AMP_W-1:0]  threshold,
  input  logic                     pix_valid,
  input  logic                     frame_done,
  input  logic [ROW_W-1:0]         row,
  input  logic [COL_W-1:0]         col,
  input  logic [SAMP_W-1:0]        sample,
  input  logic signed [PED_W-1:0]  ped,
  input  logic                     pop,
  output logic [ENTRY_W-1:0]       head,
  output logic                     empty
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int CNT_W  = $clog2(DEPTH) + 1;

  // previous-frame samples, read-first so each location is reused next frame
  logic [SAMP_W-1:0] frame_mem [2**ADDR_W];
  logic [SAMP_W-1:0] prev_q, cur_q;
  logic signed [PED_W-1:0] ped_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic vld_q, done_q, primed, ovf_pend;

  always_ff @(posedge clk) begin
    if (pix_valid) begin
      prev_q <= frame_mem[{row, col}];
      frame_mem[{row, col}] <= sample;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      vld_q  <= pix_valid;
      done_q <= frame_done;
    end
    cur_q <= sample;
    ped_q <= ped;
    row_q <= row;
    col_q <= col;
  end

  logic [SAMP_W-1:0] prev_sel;
  logic signed [AMP_W-1:0] amp;
  logic hit, wr_hit, drop, wr_en;
  logic [ENTRY_W-1:0] wr_data;
  logic [CNT_W-1:0] fill;

  assign prev_sel = primed ? prev_q : '0;
  assign amp      = AMP_W'(cur_q) - AMP_W'(prev_sel) - AMP_W'(ped_q);
  assign hit      = vld_q && (raw_mode || (amp > threshold));
  assign wr_hit   = hit && (fill < CNT_W'(DEPTH - 1));   // last slot kept for the marker
  assign drop     = hit && !wr_hit;
  assign wr_en    = wr_hit || (done_q && (fill < CNT_W'(DEPTH)));
  assign wr_data  = done_q ? {1'b1, {(ENTRY_W-2){1'b0}}, ovf_pend}
                           : {1'b0, FIELD_W'(row_q), FIELD_W'(col_q), amp};

  always_ff @(posedge clk) begin
    if (rst) begin
      primed   <= 1'b0;
      ovf_pend <= 1'b0;
    end else if (done_q) begin
      primed   <= 1'b1;
      ovf_pend <= 1'b0;
    end else if (drop) begin
      ovf_pend <= 1'b1;
    end
  end

  pzs_hit_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (pop),
    .rd_data (head),
    .empty   (empty),
    .count   (fill)
  );
endmodule

// File: rtl/pzs_packer.sv
module pzs_packer
  import pzs_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       out_ready,
  input  logic [QUADS*ENTRY_W-1:0]   heads,
  input  logic [QUADS-1:0]           empty,
  output logic [QUADS-1:0]           pop,
  output logic                       out_valid,
  output logic                       out_sop,
  output logic                       out_eop,
  output logic [31:0]                out_data
);
  arb_state_t state;
  logic [1:0] rr;
  logic [QUADS-1:0] closed;
  logic ovf_acc;
  logic [15:0] frame_no, hit_no;
  logic can, take;
  logic [ENTRY_W-1:0] cur;

  assign can  = !out_valid || out_ready;
  assign cur  = heads[rr*ENTRY_W +: ENTRY_W];
  assign take = can && (state == ARB_DRAIN) && !(&closed) && !closed[rr] && !empty[rr];

  always_comb begin
    pop     = '0;
    pop[rr] = take;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ARB_IDLE;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_data  <= '0;
      rr        <= '0;
      closed    <= '0;
      ovf_acc   <= 1'b0;
      frame_no  <= '0;
      hit_no    <= '0;
    end else if (can) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      case (state)
        ARB_IDLE: begin
          if (!(&empty)) begin
            out_valid <= 1'b1;
            out_sop   <= 1'b1;
            out_data  <= {HDR_TAG, 12'h000, frame_no};
            state     <= ARB_DRAIN;
            rr        <= '0;
            closed    <= '0;
            ovf_acc   <= 1'b0;
            hit_no    <= '0;
          end
        end
        default: begin
          if (&closed) begin
            out_valid <= 1'b1;
            out_eop   <= 1'b1;
            out_data  <= {TRL_TAG, ovf_acc, 11'h000, hit_no};
            frame_no  <= frame_no + 16'd1;
            state     <= ARB_IDLE;
          end else begin
            rr <= rr + 2'd1;
            if (take) begin
              if (cur[ENTRY_W-1]) begin
                closed[rr] <= 1'b1;
                ovf_acc    <= ovf_acc | cur[0];
              end else begin
                out_valid <= 1'b1;
                out_data  <= {rr, cur[ENTRY_W-2:0]};
                hit_no    <= hit_no + 16'd1;
              end
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pixel_zs_extractor.sv
module pixel_zs_extractor
  import pzs_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int SAMP_W = 12,
  parameter int PED_W = 12,
  parameter int FIFO_DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     raw_mode,
  input  logic signed [AMP_W-1:0]  threshold,
  input  logic                     pix_valid,
  input  logic                     frame_done,
  input  logic [ROW_W-1:0]         pix_row,
  input  logic [COL_W-1:0]         pix_col,
  input  logic [QUADS*SAMP_W-1:0]  pix_samples,
  input  logic [QUADS*PED_W-1:0]   pix_peds,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic                     out_sop,
  output logic                     out_eop,
  output logic [31:0]              out_data
);
  logic [QUADS*ENTRY_W-1:0] lane_heads;
  logic [QUADS-1:0] lane_empty, lane_pop;

  for (genvar g = 0; g < QUADS; g++) begin : g_lane
    pzs_lane #(
      .ROW_W(ROW_W), .COL_W(COL_W), .SAMP_W(SAMP_W), .PED_W(PED_W), .DEPTH(FIFO_DEPTH)
    ) u_lane (
      .clk        (clk),
      .rst        (rst),
      .raw_mode   (raw_mode),
      .threshold  (threshold),
      .pix_valid  (pix_valid),
      .frame_done (frame_done),
      .row        (pix_row),
      .col        (pix_col),
      .sample     (pix_samples[g*SAMP_W +: SAMP_W]),
      .ped        (pix_peds[g*PED_W +: PED_W]),
      .pop        (lane_pop[g]),
      .head       (lane_heads[g*ENTRY_W +: ENTRY_W]),
      .empty      (lane_empty[g])
    );
  end

  pzs_packer u_packer (
    .clk       (clk),
    .rst       (rst),
    .out_ready (out_ready),
    .heads     (lane_heads),
    .empty     (lane_empty),
    .pop       (lane_pop),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_data  (out_data)
  );
endmodule

// File: rtl/pzs_checker.sv
module pzs_checker (
  input logic        clk,
  input logic        rst,
  input logic        out_ready,
  input logic        out_valid,
  input logic        out_sop,
  input logic        out_eop,
  input logic [31:0] out_data
);
  logic in_pkt;
  logic [15:0] hits_seen, pkts;
  logic acc;
  assign acc = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt    <= 1'b0;
      hits_seen <= '0;
      pkts      <= '0;
    end else if (acc) begin
      if (out_sop) begin
        in_pkt    <= 1'b1;
        hits_seen <= '0;
      end else if (out_eop) begin
        in_pkt <= 1'b0;
        pkts   <= pkts + 16'd1;
      end else begin
        hits_seen <= hits_seen + 16'd1;
      end
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

  p_flags_excl_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_sop && out_eop));

  p_header_outside_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sop) |-> !in_pkt);

  p_body_inside_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sop) |-> in_pkt);

  p_trailer_count_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_eop) |-> (out_data[15:0] == hits_seen && out_data[31:28] == 4'hE
                                && out_data[26:16] == 11'h000));

  p_frame_number_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sop) |-> (out_data[15:0] == pkts && out_data[31:16] == 16'hA000));
endmodule

bind pixel_zs_extractor pzs_checker u_pzs_checker (
  .clk       (clk),
  .rst       (rst),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_sop   (out_sop),
  .out_eop   (out_eop),
  .out_data  (out_data)
);

// File: tb/pixel_zs_extractor_test.sv
module pixel_zs_extractor_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw_mode = 1'b0;
  logic signed [13:0] threshold = 14'sd100;
  logic pix_valid = 1'b0;
  logic frame_done = 1'b0;
  logic [3:0] pix_row = '0;
  logic [3:0] pix_col = '0;
  logic [47:0] pix_samples = '0;
  logic [47:0] pix_peds = '0;
  logic out_ready = 1'b1;
  logic out_valid, out_sop, out_eop;
  logic [31:0] out_data;

  always #4 clk = ~clk;

  pixel_zs_extractor uut (
    .clk(clk), .rst(rst), .raw_mode(raw_mode), .threshold(threshold),
    .pix_valid(pix_valid), .frame_done(frame_done), .pix_row(pix_row), .pix_col(pix_col),
    .pix_samples(pix_samples), .pix_peds(pix_peds), .out_ready(out_ready),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data)
  );

  int n_total = 0;
  int n_bad = 0;
  bit finished = 0;

  // scoreboard state
  logic [29:0] expq [4][$];
  logic [16:0] exp_evt [$];
  int exp_frame = 0;
  int m_prev [4][256];
  bit m_primed = 0;
  int m_thr = 100;
  bit m_raw = 0;
  int ped_val = 5;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  function automatic int extra_of(input int scene, input int p, input int q);
    case (scene)
      1: begin
        if (p == 3 && q == 0) return 106;   // amplitude 101: just above threshold
        if (p == 5 && q == 1) return 105;   // amplitude 100: equal, no hit
        if (p == 7 && q == 2) return 500;
        if (p == 9 && q == 3) return 106;
        return 0;
      end
      5: return (q == 0) ? 300 : 0;
      6: return (p == 2 && q == 2) ? 400 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic drive_frame(input int scene, input bit stall);
    int kept [4];
    int nh;
    bit ov;
    nh = 0;
    ov = 0;
    for (int q = 0; q < 4; q++) kept[q] = 0;
    threshold = 14'(m_thr);
    raw_mode = m_raw;
    for (int p = 0; p < 16; p++) begin
      int r, c, a;
      r = (p / 4) * 3;
      c = (p % 4) * 5;
      a = r * 16 + c;
      pix_row = 4'(r);
      pix_col = 4'(c);
      for (int q = 0; q < 4; q++) begin
        int cur, amp;
        cur = 1000 + p * 13 + q * 101 + extra_of(scene, p, q);
        amp = cur - (m_primed ? m_prev[q][a] : 0) - ped_val;
        m_prev[q][a] = cur;
        pix_samples[q*12 +: 12] = 12'(cur);
        pix_peds[q*12 +: 12] = 12'(ped_val);
        if (m_raw || amp > m_thr) begin
          if (stall && kept[q] >= 7) ov = 1;
          else begin
            kept[q]++;
            nh++;
            expq[q].push_back({8'(r), 8'(c), 14'(amp)});
          end
        end
      end
      pix_valid = 1'b1;
      tick;
      pix_valid = 1'b0;
      if (!stall) repeat (3) tick;
    end
    frame_done = 1'b1;
    tick;
    frame_done = 1'b0;
    m_primed = 1;
    exp_evt.push_back({ov, 16'(nh)});
  endtask

  task automatic wait_drained;
    while (exp_evt.size() != 0) tick;
    repeat (4) tick;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (out_sop) begin
        check(out_data[31:28] == 4'hA && out_data[15:0] == 16'(exp_frame),
              "R1 R6 header", out_data, {4'hA, 12'h0, 16'(exp_frame)});
        exp_frame++;
      end else if (out_eop) begin
        if (exp_evt.size() == 0) check(0, "R6 unexpected trailer", out_data, 0);
        else begin
          logic [16:0] ev;
          ev = exp_evt.pop_front();
          check(out_data[15:0] == ev[15:0], "R6 trailer hit count", 32'(out_data[15:0]), 32'(ev[15:0]));
          check(out_data[27] == ev[16], "R8 trailer overflow flag", 32'(out_data[27]), 32'(ev[16]));
          check(out_data[31:28] == 4'hE, "R6 trailer tag", 32'(out_data[31:28]), 32'hE);
        end
      end else begin
        int q;
        q = int'(out_data[31:30]);
        if (expq[q].size() == 0)
          check(0, m_raw ? "R4 unexpected hit" : "R3 unexpected hit", out_data, 0);
        else begin
          logic [29:0] e;
          e = expq[q].pop_front();
          // amplitude (R2), field layout (R5), per-quadrant order (R7)
          check(out_data[29:0] == e, m_raw ? "R4 R2 R5 R7 hit word" : "R3 R2 R5 R7 hit word",
                out_data, {out_data[31:30], e});
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_total++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    for (int q = 0; q < 4; q++) for (int a = 0; a < 256; a++) m_prev[q][a] = 0;
    repeat (3) tick;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 reset output idle", 32'(out_valid), 0);
    tick;
    rst = 1'b0;
    repeat (2) tick;

    // unprimed frame: previous sample counts as zero, so every pixel is a hit
    drive_frame(0, 0); wait_drained;
    // threshold edge: 101 hits, 100 does not
    drive_frame(1, 0); wait_drained;
    // frame with no hits still yields an empty packet
    drive_frame(0, 0); wait_drained;
    // negative threshold: amplitude -5 exceeds -10
    m_thr = -10;
    drive_frame(0, 0); wait_drained;
    // raw mode keeps every pixel despite a high threshold
    m_thr = 100; m_raw = 1;
    drive_frame(0, 0); wait_drained;
    m_raw = 0;

    // overflow under backpressure, R8, and hold, R9
    out_ready = 1'b0;
    drive_frame(5, 1);
    repeat (3) tick;
    @(negedge clk);
    held = out_data;
    check(out_valid == 1'b1, "R9 stalled word valid", 32'(out_valid), 1);
    tick;
    @(negedge clk);
    check(out_valid == 1'b1 && out_data == held && out_sop == 1'b1, "R9 stalled word held", out_data, held);
    tick;
    out_ready = 1'b1;
    wait_drained;

    // overflow flag clears for the next frame
    drive_frame(6, 0); wait_drained;
    // negative pedestal yields large amplitudes
    ped_val = -2000;
    drive_frame(0, 0); wait_drained;

    for (int q = 0; q < 4; q++)
      check(expq[q].size() == 0, "R7 all hits delivered", 32'(expq[q].size()), 0);
    check(exp_frame == 8, "R6 one packet per frame", 32'(exp_frame), 8);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule